// File: doc/BRIEF.md
# Context-Relative Register File with Address Translation

This block is the operand storage for a packet engine that runs four hardware threads. It holds a 128-entry general register array and four 32-entry transfer banks. Two of the transfer banks carry data into the engine: one filled from static RAM and one filled from dynamic RAM. The other two carry data out of the engine toward the same two memories. Every access carries an index plus a flag that says how to read the index. A relative index is local to the requesting thread. An absolute index names a physical entry directly.

A relative general register index selects one of 32 entries in the thread's private quarter of the array. A relative transfer index selects one of 8 entries in the thread's private quarter of the chosen bank. Absolute indices reach every entry, so threads can exchange values through an agreed entry.

The datapath side has two combinational read ports (A and B) and one clocked write port, all acting for the thread named on the context input. The memory side has one write port into the two inbound banks and one combinational read port from the two outbound banks. An index that does not fit its space raises an error flag on that port. A flagged read returns zero and a flagged write is dropped.

Top module: `ctx_regfile_map`

## Requirements
- R1: In relative mode with space code 0 (general registers), thread c with local index i (0..31) reaches physical general register c*32+i.
- R2: In absolute mode with space code 0, index 0..127 reaches that physical general register, whatever the context input. A value written by one thread is visible to every other thread.
- R3: In relative mode with a transfer space code, thread c with local index i (0..7) reaches physical entry c*8+i of the selected bank.
- R4: In absolute mode with a transfer space code, index 0..31 reaches that physical entry of the selected bank, for any thread.
- R5: Read space code 1 selects the static-RAM inbound bank and code 2 the dynamic-RAM inbound bank. A memory-side write with bank select 0 fills the static-RAM inbound bank and select 1 the dynamic-RAM inbound bank, at the clock edge.
- R6: Write space code 1 selects the static-RAM outbound bank and code 2 the dynamic-RAM outbound bank. The memory-side read with bank select 0 returns the static-RAM outbound bank and select 1 the dynamic-RAM outbound bank, combinationally.
- R7: Reads are combinational and writes take effect at the rising clock edge. A read of an entry in the same cycle it is written returns the value it held before that edge.
- R8: A relative index above 31 for general registers, or above 7 for transfer banks, raises that port's error flag. The read data is then zero, and a write carrying it changes no entry. The write error flag is low whenever write enable is low.
- R9: An absolute transfer index above 31, or space code 3, raises that port's error flag with the same zero-data / dropped-write behaviour.
- R10: A synchronous active-low reset clears every general register and every transfer entry to zero.
- R11: Read ports A and B act independently. Both may read the same entry or different entries in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx | input | 2 | Requesting thread for datapath ports |
| a_sp | input | 2 | Port A space: 0 general, 1 static inbound, 2 dynamic inbound, 3 invalid |
| a_abs | input | 1 | Port A absolute mode |
| a_idx | input | 7 | Port A index |
| a_data | output | 32 | Port A read data |
| a_err | output | 1 | Port A index error |
| b_sp | input | 2 | Port B space, same coding as A |
| b_abs | input | 1 | Port B absolute mode |
| b_idx | input | 7 | Port B index |
| b_data | output | 32 | Port B read data |
| b_err | output | 1 | Port B index error |
| wr_en | input | 1 | Datapath write enable |
| wr_sp | input | 2 | Write space: 0 general, 1 static outbound, 2 dynamic outbound, 3 invalid |
| wr_abs | input | 1 | Write absolute mode |
| wr_idx | input | 7 | Write index |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | Write index error |
| mem_wr_en | input | 1 | Memory-side write enable |
| mem_wr_bank | input | 1 | 0 static inbound, 1 dynamic inbound |
| mem_wr_idx | input | 5 | Memory-side write physical index |
| mem_wr_data | input | 32 | Memory-side write data |
| mem_rd_bank | input | 1 | 0 static outbound, 1 dynamic outbound |
| mem_rd_idx | input | 5 | Memory-side read physical index |
| mem_rd_data | output | 32 | Memory-side read data |

## Verification
The translation is checked in both directions. Entries are written through relative indices for each of the four threads and read back through absolute indices, and the reverse is done as well. A mapping that dropped or swapped the thread bits would land on the wrong physical entry and be caught. Each bank gets a distinct value at the same index, which shows that the two inbound banks and the two outbound banks are kept apart. Indices just past each limit (32 and 40 for relative general registers, 8 for relative transfers, 32 for absolute transfers) are exercised, together with the reserved space code. A rejected write is then shown to leave untouched the entry it would have aliased onto. A read taken in the same cycle as a write to that entry, before the edge, separates a combinational bypass from the required old-value behaviour.

// File: rtl/ctx_regfile_map.sv
module ctx_regfile_map #(
  parameter int DATA_W      = 32,
  parameter int NUM_CTX     = 4,
  parameter int GPR_PER_CTX = 32,
  parameter int XFR_PER_CTX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctx,
  input  logic [1:0]        a_sp,
  input  logic              a_abs,
  input  logic [6:0]        a_idx,
  output logic [DATA_W-1:0] a_data,
  output logic              a_err,
  input  logic [1:0]        b_sp,
  input  logic              b_abs,
  input  logic [6:0]        b_idx,
  output logic [DATA_W-1:0] b_data,
  output logic              b_err,
  input  logic              wr_en,
  input  logic [1:0]        wr_sp,
  input  logic              wr_abs,
  input  logic [6:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  input  logic              mem_wr_en,
  input  logic              mem_wr_bank,
  input  logic [4:0]        mem_wr_idx,
  input  logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_rd_bank,
  input  logic [4:0]        mem_rd_idx,
  output logic [DATA_W-1:0] mem_rd_data
);
  localparam int CTX_W     = $clog2(NUM_CTX);
  localparam int GLW       = $clog2(GPR_PER_CTX);
  localparam int XLW       = $clog2(XFR_PER_CTX);
  localparam int GPR_DEPTH = NUM_CTX * GPR_PER_CTX;
  localparam int XFR_DEPTH = NUM_CTX * XFR_PER_CTX;
  localparam int GAW       = CTX_W + GLW;
  localparam int XAW       = CTX_W + XLW;

  logic [DATA_W-1:0] gpr_q [GPR_DEPTH];
  logic [DATA_W-1:0] xfr_q [4][XFR_DEPTH];

  function automatic logic [GAW:0] map_addr(input logic [1:0] sp, input logic ab,
                                            input logic [6:0] idx, input logic [CTX_W-1:0] c);
    logic ok;
    logic [GAW-1:0] ph;
    ok = 1'b0;
    ph = '0;
    if (sp == 2'd0) begin
      ok = ab ? ((idx >> GAW) == 7'd0) : ((idx >> GLW) == 7'd0);
      ph = ab ? idx[GAW-1:0] : {c, idx[GLW-1:0]};
    end else if (sp != 2'd3) begin
      ok = ab ? ((idx >> XAW) == 7'd0) : ((idx >> XLW) == 7'd0);
      ph = ab ? GAW'(idx[XAW-1:0]) : GAW'({c, idx[XLW-1:0]});
    end
    return {ok, ph};
  endfunction

  logic           a_ok, b_ok, w_ok;
  logic [GAW-1:0] a_ph, b_ph, wr_phys;

  assign {a_ok, a_ph}    = map_addr(a_sp, a_abs, a_idx, ctx);
  assign {b_ok, b_ph}    = map_addr(b_sp, b_abs, b_idx, ctx);
  assign {w_ok, wr_phys} = map_addr(wr_sp, wr_abs, wr_idx, ctx);

  assign a_err  = !a_ok;
  assign b_err  = !b_ok;
  assign wr_err = wr_en && !w_ok;

  assign a_data = !a_ok ? '0 : (a_sp == 2'd0) ? gpr_q[a_ph]
                : xfr_q[{1'b0, a_sp == 2'd2}][a_ph[XAW-1:0]];
  assign b_data = !b_ok ? '0 : (b_sp == 2'd0) ? gpr_q[b_ph]
                : xfr_q[{1'b0, b_sp == 2'd2}][b_ph[XAW-1:0]];
  assign mem_rd_data = xfr_q[{1'b1, mem_rd_bank}][mem_rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GPR_DEPTH; i++) gpr_q[i] <= '0;
      for (int k = 0; k < 4; k++)
        for (int j = 0; j < XFR_DEPTH; j++) xfr_q[k][j] <= '0;
    end else begin
      if (wr_en && w_ok) begin
        if (wr_sp == 2'd0) gpr_q[wr_phys] <= wr_data;
        else xfr_q[{1'b1, wr_sp == 2'd2}][wr_phys[XAW-1:0]] <= wr_data;
      end
      if (mem_wr_en) xfr_q[{1'b0, mem_wr_bank}][mem_wr_idx] <= mem_wr_data;
    end
  end

  AST_GPR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_sp == 2'd0) |=> gpr_q[$past(wr_phys)] == $past(wr_data)); // R7
  AST_OUT_BANK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_sp == 2'd2) |=> xfr_q[3][$past(wr_phys[XAW-1:0])] == $past(wr_data)); // R6
  AST_MEM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> xfr_q[{1'b0, $past(mem_wr_bank)}][$past(mem_wr_idx)] == $past(mem_wr_data)); // R5
  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a_err |-> a_data == '0) and (b_err |-> b_data == '0)); // R8
  AST_WR_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_err); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (a_data == '0 && b_data == '0 && mem_rd_data == '0)); // R10
endmodule

// File: tb/ctx_regfile_map_tb.sv
module ctx_regfile_map_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] ctx = 0, a_sp = 0, b_sp = 0, wr_sp = 0;
  logic a_abs = 0, b_abs = 0, wr_abs = 0, wr_en = 0, mem_wr_en = 0, mem_wr_bank = 0, mem_rd_bank = 0;
  logic [6:0] a_idx = 0, b_idx = 0, wr_idx = 0;
  logic [4:0] mem_wr_idx = 0, mem_rd_idx = 0;
  logic [31:0] wr_data = 0, mem_wr_data = 0;
  logic [31:0] a_data, b_data, mem_rd_data;
  logic a_err, b_err, wr_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctx_regfile_map u_dut (.clk, .rst_n, .ctx, .a_sp, .a_abs, .a_idx, .a_data, .a_err,
    .b_sp, .b_abs, .b_idx, .b_data, .b_err, .wr_en, .wr_sp, .wr_abs, .wr_idx, .wr_data,
    .wr_err, .mem_wr_en, .mem_wr_bank, .mem_wr_idx, .mem_wr_data, .mem_rd_bank,
    .mem_rd_idx, .mem_rd_data);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic dp_write(input logic [1:0] c, input logic [1:0] sp, input logic ab,
                          input logic [6:0] idx, input logic [31:0] d);
    @(negedge clk);
    ctx = c; wr_en = 1; wr_sp = sp; wr_abs = ab; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic mem_write(input logic bank, input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    mem_wr_en = 1; mem_wr_bank = bank; mem_wr_idx = idx; mem_wr_data = d;
    @(negedge clk);
    mem_wr_en = 0;
  endtask

  task automatic rd_a(input logic [1:0] c, input logic [1:0] sp, input logic ab,
                      input logic [6:0] idx, output logic [31:0] d, output logic e);
    ctx = c; a_sp = sp; a_abs = ab; a_idx = idx;
    #0.5; d = a_data; e = a_err;
  endtask

  task automatic rd_mem(input logic bank, input logic [4:0] idx, output logic [31:0] d);
    mem_rd_bank = bank; mem_rd_idx = idx;
    #0.5; d = mem_rd_data;
  endtask

  task automatic test_reset;
    logic [31:0] d; logic e; int nz;
    nz = 0;
    for (int i = 0; i < 128; i++) begin
      rd_a(0, 0, 1, 7'(i), d, e);
      if (d != 0 || e) nz++;
    end
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 32; i++) begin
        rd_mem(k[0], 5'(i), d);
        if (d != 0) nz++;
      end
    chk("R10 nonzero entries after reset", 32'(nz), 0);
  endtask

  task automatic test_rel_gpr;
    logic [31:0] d; logic e;
    for (int c = 0; c < 4; c++) dp_write(2'(c), 0, 0, 7'd5, 32'hA000_0000 + 32'(c));
    for (int c = 0; c < 4; c++) begin
      rd_a(0, 0, 1, 7'(c * 32 + 5), d, e);
      chk($sformatf("R1 ctx%0d rel5 -> abs", c), d, 32'hA000_0000 + 32'(c));
    end
    rd_a(2, 0, 0, 7'd5, d, e);
    chk("R1 ctx2 rel read own slice", d, 32'hA000_0002);
    rd_a(2, 0, 0, 7'd31, d, e);
    chk("R1 ctx2 rel31 untouched", d, 0);
  endtask

  task automatic test_abs_gpr;
    logic [31:0] d; logic e;
    dp_write(0, 0, 1, 7'd100, 32'h1234_5678);
    ctx = 2; b_sp = 0; b_abs = 1; b_idx = 7'd100; #0.5;
    chk("R2 ctx2 abs read of ctx0 write", b_data, 32'h1234_5678);
    rd_a(3, 0, 0, 7'd4, d, e);
    chk("R2 abs100 equals ctx3 rel4", d, 32'h1234_5678);
    dp_write(1, 0, 1, 7'd127, 32'hFFFF_0001);
    rd_a(3, 0, 0, 7'd31, d, e);
    chk("R2 abs127 top entry", d, 32'hFFFF_0001);
  endtask

  task automatic test_rel_xfr;
    logic [31:0] d;
    for (int c = 0; c < 4; c++) dp_write(2'(c), 1, 0, 7'd3, 32'hB000_0000 + 32'(c));
    for (int c = 0; c < 4; c++) begin
      rd_mem(0, 5'(c * 8 + 3), d);
      chk($sformatf("R3 ctx%0d rel3 -> outbound static", c), d, 32'hB000_0000 + 32'(c));
    end
  endtask

  task automatic test_inbound;
    logic [31:0] d; logic e;
    mem_write(1, 5'd29, 32'hD0D0_0029);
    mem_write(0, 5'd29, 32'h5050_0029);
    rd_a(1, 2, 1, 7'd29, d, e);
    chk("R4 R5 abs29 dynamic inbound", d, 32'hD0D0_0029);
    rd_a(3, 2, 0, 7'd5, d, e);
    chk("R3 R5 ctx3 rel5 dynamic inbound", d, 32'hD0D0_0029);
    rd_a(0, 1, 1, 7'd29, d, e);
    chk("R5 abs29 static inbound", d, 32'h5050_0029);
  endtask

  task automatic test_outbound;
    logic [31:0] d;
    dp_write(1, 2, 1, 7'd17, 32'hCAFE_0017);
    rd_mem(1, 5'd17, d);
    chk("R6 dynamic outbound abs17", d, 32'hCAFE_0017);
    rd_mem(0, 5'd17, d);
    chk("R6 static outbound abs17 untouched", d, 0);
  endtask

  task automatic test_rw_same_cycle;
    logic [31:0] d; logic e;
    @(negedge clk);
    ctx = 0; wr_en = 1; wr_sp = 0; wr_abs = 1; wr_idx = 7'd64; wr_data = 32'h0BAD_F00D;
    rd_a(0, 0, 1, 7'd64, d, e);
    chk("R7 read before edge returns old", d, 0);
    @(negedge clk);
    wr_en = 0;
    rd_a(0, 0, 1, 7'd64, d, e);
    chk("R7 read after edge returns new", d, 32'h0BAD_F00D);
  endtask

  task automatic test_range;
    logic [31:0] d; logic e;
    rd_a(1, 0, 0, 7'd32, d, e);
    chk("R8 rel gpr 32 err", 32'(e), 1);
    chk("R8 rel gpr 32 data", d, 0);
    rd_a(1, 1, 0, 7'd8, d, e);
    chk("R8 rel xfr 8 err", 32'(e), 1);
    @(negedge clk);
    ctx = 1; wr_en = 1; wr_sp = 0; wr_abs = 0; wr_idx = 7'd40; wr_data = 32'hDEAD_BEEF;
    #0.5;
    chk("R8 rel write 40 err", 32'(wr_err), 1);
    @(negedge clk);
    wr_en = 0; #0.5;
    chk("R8 wr_err low without enable", 32'(wr_err), 0);
    rd_a(0, 0, 1, 7'd40, d, e);
    chk("R8 alias abs40 unchanged", d, 0);
    rd_a(0, 0, 1, 7'd8, d, e);
    chk("R8 abs8 unchanged", d, 0);
    rd_a(0, 2, 1, 7'd32, d, e);
    chk("R9 abs xfr 32 err", 32'(e), 1);
    chk("R9 abs xfr 32 data", d, 0);
    rd_a(0, 3, 1, 7'd0, d, e);
    chk("R9 space 3 read err", 32'(e), 1);
    @(negedge clk);
    wr_en = 1; wr_sp = 3; wr_abs = 1; wr_idx = 7'd0; wr_data = 32'h1;
    #0.5;
    chk("R9 space 3 write err", 32'(wr_err), 1);
    @(negedge clk);
    wr_en = 0;
    rd_mem(0, 5'd0, d);
    chk("R9 space 3 write left bank clear", d, 0);
  endtask

  task automatic test_dual;
    ctx = 0; a_sp = 0; a_abs = 1; a_idx = 7'd100; b_sp = 0; b_abs = 1; b_idx = 7'd100; #0.5;
    chk("R11 A same entry", a_data, 32'h1234_5678);
    chk("R11 B same entry", b_data, 32'h1234_5678);
    b_idx = 7'd64; #0.5;
    chk("R11 A different entry", a_data, 32'h1234_5678);
    chk("R11 B different entry", b_data, 32'h0BAD_F00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_rel_gpr();
    test_abs_gpr();
    test_rel_xfr();
    test_inbound();
    test_outbound();
    test_rw_same_cycle();
    test_range();
    test_dual();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule